// File: doc/BRIEF.md
# Quad Recirculating Serial Delay Line

This block holds four independent 64-stage serial shift lanes, named A, B, C and D. Each lane has its own clock, its own serial input and its own serial output. On every rising edge of its clock a lane moves its contents one stage toward the output. A 2:1 selector in front of the first stage picks what enters that stage. It takes either the external serial input, which gives a fixed 64-edge delay, or the lane's own output, which makes the lane a circulating 64-bit memory.

Two recirculation controls set the selector. One governs lanes A and B together, the other governs lanes C and D. The serial output comes straight from the last stage, so lanes can be chained into longer delays. Each lane also has a read-only tap: a 6-bit index selects any stage and shows its current bit. Index 0 is the stage that was loaded most recently, and index 63 is the stage that drives the serial output.

The storage has no reset, and its contents are undefined until the lane has taken 64 edges. Each lane is a clock domain of its own, and no signal is synchronized between lanes.

Top module: `quad_recirc_delay`

## Requirements
- R1: With recirculation off, a bit presented at a lane's serial input appears at that lane's serial output after exactly 64 rising edges of that lane's clock, counting the edge that captured it.
- R2: A lane changes state only on a rising edge of its own clock bit (lane A = bit 0 up to lane D = bit 3). Edges on the other lanes' clocks leave its output and taps unchanged.
- R3: With recirculation on (control = 1), the lane's serial output is written into stage 0 and the serial input has no effect.
- R4: With recirculation off (control = 0), the serial input is written into stage 0.
- R5: `recirc_ab` controls lanes A and B only, and `recirc_cd` controls lanes C and D only.
- R6: After 64 edges in recirculation mode, every stage of the lane holds the value it held before those edges.
- R7: The serial output is the last stage with no added register. Feeding lane A's output into lane B's input on a shared clock gives a 128-edge delay.
- R8: The recirculation control is sampled on the same edge as the shift, so the first edge after the control changes already uses the new selection.
- R9: Tap index k (lane A in `tap_sel[5:0]` up to lane D in `tap_sel[23:18]`) shows stage k. Stage 0 is the newest bit and stage 63 equals the serial output. The tap index has no effect on shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | 4 | Per-lane shift clock, bit 0 = lane A |
| ser_in | input | 4 | Per-lane external serial input |
| recirc_ab | input | 1 | Recirculation control for lanes A and B |
| recirc_cd | input | 1 | Recirculation control for lanes C and D |
| tap_sel | input | 24 | Per-lane 6-bit stage index for the tap |
| ser_out | output | 4 | Per-lane serial output, the last stage |
| tap_out | output | 4 | Per-lane bit of the selected stage |

## Verification
A wrong bit in a stage shows on the tap at once when that stage is selected. It reaches the serial output within at most 64 edges of that lane's own clock. A wrong feed selection corrupts stage 0, which the tap at index 0 shows after one edge. The bench therefore moves the tap index at random on every cycle and compares both outputs of every lane to a behavioural queue model after each edge.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
    localparam int LANES = 4;

    typedef enum logic {
        FEED_EXT  = 1'b0,
        FEED_LOOP = 1'b1
    } feed_mode_e;
endpackage

// File: rtl/rdl_feed_sel.sv
module rdl_feed_sel
    import rdl_pkg::*;
(
    input  feed_mode_e mode,
    input  logic       ext_bit,
    input  logic       loop_bit,
    output logic       feed_bit
);
    always_comb begin
        feed_bit = ext_bit;
        unique case (mode)
            FEED_EXT:  feed_bit = ext_bit;
            FEED_LOOP: feed_bit = loop_bit;
        endcase
    end
endmodule

// File: rtl/rdl_stage_chain.sv
module rdl_stage_chain #(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             feed_bit,
    output logic [DEPTH-1:0] stages
);
    // stage 0 takes the new bit; stage DEPTH-1 is the lane output
    always_ff @(posedge clk) begin
        stages <= {stages[DEPTH-2:0], feed_bit};
    end
endmodule

// File: rtl/rdl_tap_mux.sv
module rdl_tap_mux #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] stages,
    input  logic [IDX_W-1:0] sel,
    output logic             bit_out
);
    always_comb begin
        bit_out = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (sel == IDX_W'(k)) bit_out = stages[k];
        end
    end
endmodule

// File: rtl/quad_recirc_delay.sv
module quad_recirc_delay
    import rdl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [LANES-1:0]       lane_clk,
    input  logic [LANES-1:0]       ser_in,
    input  logic                   recirc_ab,
    input  logic                   recirc_cd,
    input  logic [LANES*IDX_W-1:0] tap_sel,
    output logic [LANES-1:0]       ser_out,
    output logic [LANES-1:0]       tap_out
);
    localparam int PAIR = 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        feed_mode_e       mode;
        logic             feed;
        logic [DEPTH-1:0] stg;
        logic             ctl;

        // lanes 0,1 share the first control, lanes 2,3 the second
        assign ctl  = (g < PAIR) ? recirc_ab : recirc_cd;
        assign mode = ctl ? FEED_LOOP : FEED_EXT;

        rdl_feed_sel u_sel (
            .mode     (mode),
            .ext_bit  (ser_in[g]),
            .loop_bit (stg[DEPTH-1]),
            .feed_bit (feed)
        );

        rdl_stage_chain #(.DEPTH(DEPTH)) u_chain (
            .clk      (lane_clk[g]),
            .feed_bit (feed),
            .stages   (stg)
        );

        rdl_tap_mux #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tap (
            .stages  (stg),
            .sel     (tap_sel[g*IDX_W +: IDX_W]),
            .bit_out (tap_out[g])
        );

        assign ser_out[g] = stg[DEPTH-1];
    end
endmodule

// File: rtl/quad_recirc_delay_chk.sv
module quad_recirc_delay_chk
    import rdl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic [LANES-1:0]       lane_clk,
    input logic [LANES-1:0]       ser_in,
    input logic                   recirc_ab,
    input logic                   recirc_cd,
    input logic [LANES*IDX_W-1:0] tap_sel,
    input logic [LANES-1:0]       ser_out,
    input logic [LANES-1:0]       tap_out
);
    localparam int CW = IDX_W + 2;

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic [CW-1:0]    edges = '0;
        logic             warm;
        logic             rc;
        logic [IDX_W-1:0] sel;

        assign rc   = (g < 2) ? recirc_ab : recirc_cd;
        assign sel  = tap_sel[g*IDX_W +: IDX_W];
        assign warm = (edges > CW'(DEPTH));

        always_ff @(posedge lane_clk[g]) begin
            if (!warm) edges <= edges + 1'b1;
        end

        // R4: load mode writes the serial input into stage 0
        a_r4_load_takes_input: assert property (@(posedge lane_clk[g]) disable iff (!warm)
            (sel == '0 && !$past(rc)) |-> (tap_out[g] == $past(ser_in[g])));

        // R3: recirculation writes the lane output into stage 0
        a_r3_loop_feeds_back: assert property (@(posedge lane_clk[g]) disable iff (!warm)
            (sel == '0 && $past(rc)) |-> (tap_out[g] == $past(ser_out[g])));

        // R9: the last tap index matches the serial output
        a_r9_tap_last_is_output: assert property (@(posedge lane_clk[g]) disable iff (!warm)
            (sel == IDX_W'(DEPTH-1)) |-> (tap_out[g] == ser_out[g]));

        // R1: the second-to-last stage moves to the output on the next edge
        a_r1_shift_to_output: assert property (@(posedge lane_clk[g]) disable iff (!warm)
            (sel == IDX_W'(DEPTH-2)) |=> (ser_out[g] == $past(tap_out[g])));
    end
endmodule

bind quad_recirc_delay quad_recirc_delay_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .lane_clk  (lane_clk),
    .ser_in    (ser_in),
    .recirc_ab (recirc_ab),
    .recirc_cd (recirc_cd),
    .tap_sel   (tap_sel),
    .ser_out   (ser_out),
    .tap_out   (tap_out)
);

// File: tb/quad_recirc_delay_test.sv
module quad_recirc_delay_test;
    localparam int N = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic [3:0]    gate = 4'b0000;
    logic [3:0]    din = 4'b0000;
    logic          casc = 1'b0;
    logic          rab = 1'b0;
    logic          rcd = 1'b0;
    logic [4*IW-1:0] tap_sel = '0;
    logic [3:0]    lane_clk;
    logic [3:0]    ser_in;
    logic [3:0]    ser_out;
    logic [3:0]    tap_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit mq [4][N];
    int fillc [4];
    bit snap [4][N];

    always #2 clk = ~clk;

    assign lane_clk = {4{clk}} & gate;
    assign ser_in   = {din[3:2], casc ? ser_out[0] : din[1], din[0]};

    quad_recirc_delay uut (
        .lane_clk  (lane_clk),
        .ser_in    (ser_in),
        .recirc_ab (rab),
        .recirc_cd (rcd),
        .tap_sel   (tap_sel),
        .ser_out   (ser_out),
        .tap_out   (tap_out)
    );

    // behavioural model: one queue per lane, index 0 newest
    initial for (int i = 0; i < 4; i++) fillc[i] = 0;

    always @(posedge clk) begin
        bit po [4];
        for (int i = 0; i < 4; i++) po[i] = mq[i][N-1];
        for (int i = 0; i < 4; i++) begin
            if (gate[i]) begin
                bit ctl, ext, f;
                ctl = (i < 2) ? rab : rcd;
                ext = (i == 1 && casc) ? po[0] : din[i];
                f   = ctl ? po[i] : ext;
                for (int k = N-1; k > 0; k--) mq[i][k] = mq[i][k-1];
                mq[i][0] = f;
                fillc[i]++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int lane, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s lane %0d actual %0d expected %0d", tag, lane, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < 4; i++) begin
            if (fillc[i] >= N) begin
                int s;
                s = int'(tap_sel[i*IW +: IW]);
                chk(ser_out[i] == mq[i][N-1], tag, i, int'(ser_out[i]), int'(mq[i][N-1]));
                chk(tap_out[i] == mq[i][s], "R9", i, int'(tap_out[i]), int'(mq[i][s]));
            end
        end
    endtask

    task automatic rand_taps();
        for (int i = 0; i < 4; i++) tap_sel[i*IW +: IW] = IW'($urandom % N);
    endtask

    task automatic cyc(input string tag);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        // fill every lane in load mode (R4)
        gate = 4'b1111;
        for (int c = 0; c < 2*N; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R4");
        end

        // R1: single pulse through lane A
        din = 4'b0000;
        tap_sel = '0;
        for (int c = 0; c < N; c++) cyc("R1");
        din[0] = 1'b1;
        cyc("R1");
        din[0] = 1'b0;
        n = 1;
        while (!ser_out[0] && n < 3*N) begin
            cyc("R1");
            n++;
        end
        chk(n == N, "R1", 0, n, N);

        // R5: only the pair of lanes under recirculation loops
        rab = 1'b1; rcd = 1'b0;
        for (int c = 0; c < 80; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R5");
        end
        rab = 1'b0; rcd = 1'b1;
        for (int c = 0; c < 80; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R5");
        end

        // R3 and R6: full rotation restores every stage
        rab = 1'b1; rcd = 1'b1;
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < N; k++) snap[i][k] = mq[i][k];
        for (int c = 0; c < N; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R3");
        end
        gate = 4'b0000;
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < 4; i++) tap_sel[i*IW +: IW] = IW'(k);
            #1;
            for (int i = 0; i < 4; i++)
                chk(tap_out[i] == snap[i][k], "R6", i, int'(tap_out[i]), int'(snap[i][k]));
        end
        @(negedge clk);

        // R2: only lane C is clocked; others must hold
        rab = 1'b0; rcd = 1'b0;
        gate = 4'b0100;
        for (int c = 0; c < 40; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R2");
        end
        gate = 4'b1011;
        for (int c = 0; c < 40; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R2");
        end
        gate = 4'b1111;

        // R8: control toggled every edge; first edge uses new selection
        tap_sel = '0;
        for (int c = 0; c < 40; c++) begin
            bit s;
            s = ser_out[0];
            rab = 1'b1;
            din[0] = ~s;
            cyc("R8");
            chk(tap_out[0] == s, "R8", 0, int'(tap_out[0]), int'(s));
            rab = 1'b0;
            s = ~ser_out[0];
            din[0] = s;
            rcd = c[0];
            din[3:1] = 3'($urandom);
            cyc("R8");
            chk(tap_out[0] == s, "R8", 0, int'(tap_out[0]), int'(s));
        end
        rcd = 1'b0;

        // R7: cascade lane A into lane B on a shared clock
        casc = 1'b1;
        din = 4'b0000;
        for (int c = 0; c < 2*N; c++) cyc("R7");
        din[0] = 1'b1;
        cyc("R7");
        din[0] = 1'b0;
        n = 1;
        while (!ser_out[1] && n < 4*N) begin
            if (n == N) chk(ser_out[0] == 1'b1, "R7", 0, int'(ser_out[0]), 1);
            cyc("R7");
            n++;
        end
        chk(n == 2*N, "R7", 1, n, 2*N);
        for (int c = 0; c < 30; c++) begin
            din = 4'($urandom);
            rand_taps();
            cyc("R7");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule